// File: doc/BRIEF.md
# MDIO Management Register Reader

This block lets a host read 16-bit registers from an external Ethernet PHY over the two-wire MDC/MDIO management interface. The host has a small byte-wide register file. It loads a PHY address and a PHY register address, picks an MDC clock rate and sets a command bit to start a read. The block then runs the complete serial read frame on its own. This covers the preamble, the start and opcode fields, both addresses, the turnaround and sixteen data bits.

While the frame runs, a busy flag and the command bit both read as one. Software polls either of them. When the frame ends, the PHY's value appears in two byte registers: a low byte and a high byte, so the full value is low + (high << 8). A management reset bit in the control register stops a transfer that is running and holds the sequencer idle. It does this without touching any other logic.

Top module: `mdioRegReader`

## Requirements
- R1: After reset every host register reads 0x00, and MDC, MDIO output and MDIO output enable are all low.
- R2: A control write (offset 2) with bit 0 set and bit 7 clear, made while idle, sets the busy flag (offset 3, bit 0) on the next cycle. The flag then stays high for exactly 128 × N/2 clock cycles, where N is the selected divisor.
- R3: Control bits [2:1] select the MDC divisor: 0 gives 4, 1 gives 8, 2 gives 20 and 3 gives 40. In a transfer, MDC starts low and toggles every N/2 cycles. It is low whenever the block is idle.
- R4: The driven bit sequence runs as follows. Bits 0 to 31 are 32 ones, bits 32 to 35 are 0,1,1,0, bits 36 to 40 are the PHY address (offset 1) MSB first, and bits 41 to 45 are the register address (offset 0) MSB first. Each bit is put out when MDC falls, or at the start of the transfer for bit 0.
- R5: Output enable is high only during bits 0 to 45 of a transfer. The two turnaround bits and the sixteen data bits leave MDIO released. MDIO output reads 0 whenever output enable is low.
- R6: Bits 48 to 63 are sampled from MDIO input on the rising MDC edge, MSB first. When busy drops, the low byte appears at offset 4 and the high byte at offset 5.
- R7: Control bit 0 reads 1 while a transfer runs. It clears itself in the same cycle that busy falls.
- R8: A control write with bit 7 clear, made while busy, is ignored. The divisor and the command bit keep their values.
- R9: Writing control bit 7 as 1 aborts a running transfer on the next cycle. Busy goes to 0, MDC goes low, output enable goes low, and the data registers keep their old values. While bit 7 is written as 1, no transfer starts.
- R10: Offsets 0 and 1 keep the low 5 bits written and read 0 in bits [7:5]. Offset 2 reads {reset bit, 0000, divisor select, command bit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 3 | Host register offset |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data for hostAddr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the wire |

## Verification
Reads are run with the divisors 4, 20 and 40. Using more than one divisor separates a correct half-period count from an off-by-one. It also catches a select that is decoded to the wrong divisor. The PHY addresses, register addresses and returned values are chosen to be asymmetric: 0x1F/0x01, 0x00/0x12, 0x0A/0x15, and data 0xA5C3, 0x3C5A, 0x7E01, 0x8001. With these values, swapped fields, a reversed bit order, swapped bytes or a sample taken one bit late all change the observed result. A read is aborted part-way, a start is attempted with the reset bit set, and a control write is made during a transfer. These cases separate a correct abort, which keeps the old data, and a correctly ignored write from a block that accepts either.

// File: rtl/mmr_pkg.sv
package mmr_pkg;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_W    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DATA_START = FRAME_W + 2;
  localparam int TOTAL_BITS = DATA_START + DATA_W;
  localparam int IDX_W      = $clog2(TOTAL_BITS);

  localparam logic [2:0] OFS_REG  = 3'd0;
  localparam logic [2:0] OFS_PHY  = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_STAT = 3'd3;
  localparam logic [2:0] OFS_DLO  = 3'd4;
  localparam logic [2:0] OFS_DHI  = 3'd5;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
  } mmStrobe_t;
endpackage

// File: rtl/mmRegs.sv
module mmRegs
  import mmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [2:0]        hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  input  logic              busyIn,
  input  logic              doneIn,
  input  logic [DATA_W-1:0] resultIn,
  output logic [REG_W-1:0]  regAddr,
  output logic [PHY_W-1:0]  phyAddr,
  output logic [1:0]        divSel,
  output logic              startReq,
  output logic              holdReq
);
  localparam int HALF_W = DATA_W / 2;

  logic ctrlWr;
  logic rstBit;
  logic cmdQ;
  logic unusedBits;

  assign ctrlWr     = hostWe && (hostAddr == OFS_CTRL);
  assign holdReq    = ctrlWr ? hostWrData[7] : rstBit;
  assign startReq   = ctrlWr && !busyIn && hostWrData[0] && !hostWrData[7];
  assign unusedBits = ^hostWrData[6:3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddr <= '0;
      phyAddr <= '0;
      divSel  <= '0;
      rstBit  <= 1'b0;
      cmdQ    <= 1'b0;
    end else begin
      if (hostWe && hostAddr == OFS_REG) regAddr <= hostWrData[REG_W-1:0];
      if (hostWe && hostAddr == OFS_PHY) phyAddr <= hostWrData[PHY_W-1:0];
      if (ctrlWr) begin
        if (!busyIn) begin
          divSel <= hostWrData[2:1];
          rstBit <= hostWrData[7];
        end else if (hostWrData[7]) begin
          rstBit <= 1'b1;
        end
      end
      if (holdReq || doneIn) cmdQ <= 1'b0;
      else if (startReq)     cmdQ <= 1'b1;
    end
  end

  always_comb begin
    case (hostAddr)
      OFS_REG:  hostRdData = {{(8-REG_W){1'b0}}, regAddr};
      OFS_PHY:  hostRdData = {{(8-PHY_W){1'b0}}, phyAddr};
      OFS_CTRL: hostRdData = {rstBit, 4'b0000, divSel, cmdQ};
      OFS_STAT: hostRdData = {7'b0, busyIn};
      OFS_DLO:  hostRdData = resultIn[HALF_W-1:0];
      OFS_DHI:  hostRdData = resultIn[DATA_W-1:HALF_W];
      default:  hostRdData = 8'h00;
    endcase
  end

  // command bit and sequencer busy flag move together
  assert_cmd_tracks_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ == busyIn);

  // control writes without the reset bit are dropped during a transfer
  assert_ctrl_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busyIn && !hostWrData[7]) |=> ($stable(divSel) && $stable(rstBit)));
endmodule

// File: rtl/mmCtrl.sv
module mmCtrl
  import mmr_pkg::*;
#(
  parameter int DIV_CODE0 = 4,
  parameter int DIV_CODE1 = 8,
  parameter int DIV_CODE2 = 20,
  parameter int DIV_CODE3 = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       holdReq,
  input  logic [1:0] divSel,
  output logic       busy,
  output logic       mdc,
  output logic       mdioOe,
  output mmStrobe_t  strb
);
  localparam int HALF0    = DIV_CODE0 / 2;
  localparam int HALF1    = DIV_CODE1 / 2;
  localparam int HALF2    = DIV_CODE2 / 2;
  localparam int HALF3    = DIV_CODE3 / 2;
  localparam int HALF_A   = (HALF0 > HALF1) ? HALF0 : HALF1;
  localparam int HALF_B   = (HALF2 > HALF3) ? HALF2 : HALF3;
  localparam int HALF_MAX = (HALF_A > HALF_B) ? HALF_A : HALF_B;
  localparam int CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic             busyQ;
  logic             mdcQ;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] halfLim;
  logic [IDX_W-1:0] bitIdx;
  logic             halfEnd;
  logic             riseEv;
  logic             fallEv;
  logic             lastBit;

  always_comb begin
    case (divSel)
      2'd0:    halfLim = CNT_W'(HALF0 - 1);
      2'd1:    halfLim = CNT_W'(HALF1 - 1);
      2'd2:    halfLim = CNT_W'(HALF2 - 1);
      default: halfLim = CNT_W'(HALF3 - 1);
    endcase
  end

  assign halfEnd = busyQ && (halfCnt == halfLim);
  assign riseEv  = halfEnd && !mdcQ;
  assign fallEv  = halfEnd && mdcQ;
  assign lastBit = (bitIdx == IDX_W'(TOTAL_BITS - 1));

  always_comb begin
    strb.load   = startReq && !holdReq && !busyQ;
    strb.shift  = !holdReq && fallEv && !lastBit;
    strb.sample = !holdReq && riseEv && (bitIdx >= IDX_W'(DATA_START));
    strb.finish = !holdReq && fallEv && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || holdReq) begin
      busyQ   <= 1'b0;
      mdcQ    <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (strb.load) begin
      busyQ   <= 1'b1;
      mdcQ    <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (busyQ) begin
      if (halfEnd) begin
        halfCnt <= '0;
        mdcQ    <= !mdcQ;
        if (strb.shift)  bitIdx <= bitIdx + IDX_W'(1);
        if (strb.finish) begin
          busyQ  <= 1'b0;
          bitIdx <= '0;
        end
      end else begin
        halfCnt <= halfCnt + CNT_W'(1);
      end
    end
  end

  assign busy   = busyQ;
  assign mdc    = mdcQ;
  assign mdioOe = busyQ && (bitIdx < IDX_W'(FRAME_W));

  // MDC rests low outside a transfer
  assert_idle_mdc_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !mdcQ);

  // a transfer only begins after an accepted host command
  assert_start_from_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(startReq));

  // MDC edges only at the end of a half period
  assert_mdc_edge_timing_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ) && !$stable(mdcQ)) |-> ($past(halfCnt) == $past(halfLim)));
endmodule

// File: rtl/mmData.sv
module mmData
  import mmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mmStrobe_t         strb,
  input  logic [PHY_W-1:0]  phyAddr,
  input  logic [REG_W-1:0]  regAddr,
  input  logic              mdioIn,
  output logic              txBit,
  output logic [DATA_W-1:0] result
);
  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      result  <= '0;
    end else begin
      if (strb.load)
        txShift <= {{PRE_LEN{1'b1}}, 2'b01, 2'b10, phyAddr, regAddr};
      else if (strb.shift)
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (strb.sample) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (strb.finish) result  <= rxShift;
    end
  end

  assign txBit = txShift[FRAME_W-1];

  // result registers only move at the end of a completed frame
  assert_result_on_finish_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> $past(strb.finish));
endmodule

// File: rtl/mdioRegReader.sv
module mdioRegReader
  import mmr_pkg::*;
#(
  parameter int DIV_CODE0 = 4,
  parameter int DIV_CODE1 = 8,
  parameter int DIV_CODE2 = 20,
  parameter int DIV_CODE3 = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWe,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  output logic       mdc,
  output logic       mdioOut,
  output logic       mdioOe,
  input  logic       mdioIn
);
  logic              busy;
  logic              startReq;
  logic              holdReq;
  logic [1:0]        divSel;
  logic [REG_W-1:0]  regAddr;
  logic [PHY_W-1:0]  phyAddr;
  logic [DATA_W-1:0] result;
  logic              txBit;
  mmStrobe_t         strb;

  mmRegs u_regs (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .busyIn(busy),
    .doneIn(strb.finish), .resultIn(result), .regAddr(regAddr),
    .phyAddr(phyAddr), .divSel(divSel), .startReq(startReq), .holdReq(holdReq)
  );

  mmCtrl #(
    .DIV_CODE0(DIV_CODE0), .DIV_CODE1(DIV_CODE1),
    .DIV_CODE2(DIV_CODE2), .DIV_CODE3(DIV_CODE3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .holdReq(holdReq),
    .divSel(divSel), .busy(busy), .mdc(mdc), .mdioOe(mdioOe), .strb(strb)
  );

  mmData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .phyAddr(phyAddr), .regAddr(regAddr),
    .mdioIn(mdioIn), .txBit(txBit), .result(result)
  );

  assign mdioOut = mdioOe & txBit;

  // released bus never carries a driven one
  assert_released_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !mdioOe |-> !mdioOut);
endmodule

// File: tb/mdioRegReader_bench.sv
`timescale 1ns/1ps
module mdioRegReader_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWe = 1'b0;
  logic [2:0] hostAddr = 3'd3;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic       mdc, mdioOut, mdioOe;
  logic       mdioIn = 1'b1;

  always #4 clk = ~clk;

  mdioRegReader u_mdioRegReader (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model state
  bit          mBusy = 0, mRst = 0;
  int          mT = 0, mH = 2;
  logic [4:0]  mReg = 0, mPhy = 0, mFReg = 0, mFPhy = 0;
  logic [1:0]  mDiv = 0;
  logic [15:0] mRes = 0, mRet = 0;
  logic [15:0] phyVal = 16'h0000;

  function automatic int divOf(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 8;
      2'd2: return 20;
      default: return 40;
    endcase
  endfunction

  function automatic logic frameBit(input int b);
    if (b < 32) return 1'b1;
    if (b == 32 || b == 35) return 1'b0;
    if (b == 33 || b == 34) return 1'b1;
    if (b <= 40) return mFPhy[4 - (b - 36)];
    return mFReg[4 - (b - 41)];
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, mReg};
      3'd1: return {3'b0, mPhy};
      3'd2: return {mRst, 4'b0, mDiv, mBusy};
      3'd3: return {7'b0, mBusy};
      3'd4: return mRes[7:0];
      3'd5: return mRes[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R10";
      3'd2: return "R7";
      3'd3: return "R2";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // model update on every edge, comparison 2 ns later
  always @(posedge clk) begin
    bit b0;
    bit ctrlWr;
    int bitNo;
    bit eMdc, eOe, eOut;
    if (!rstN) begin
      mBusy = 0; mRst = 0; mT = 0; mReg = 0; mPhy = 0; mDiv = 0; mRes = 0;
    end else begin
      b0 = mBusy;
      ctrlWr = hostWe && hostAddr == 3'd2;
      if (ctrlWr && hostWrData[7]) begin
        mRst = 1; mBusy = 0;
        if (!b0) mDiv = hostWrData[2:1];
      end else begin
        if (mBusy) begin
          mT++;
          if (mT == 128 * mH) begin mBusy = 0; mRes = mRet; end
        end
        if (ctrlWr && !b0) begin
          mRst = 0; mDiv = hostWrData[2:1];
          if (hostWrData[0]) begin
            mBusy = 1; mT = 0; mH = divOf(mDiv) / 2;
            mFPhy = mPhy; mFReg = mReg; mRet = phyVal;
          end
        end
      end
      if (hostWe && hostAddr == 3'd0) mReg = hostWrData[4:0];
      if (hostWe && hostAddr == 3'd1) mPhy = hostWrData[4:0];
    end
    #2;
    if (rstN) begin
      bitNo = mT / (2 * mH);
      eMdc = mBusy && ((mT / mH) % 2 == 1);
      eOe  = mBusy && bitNo < 46;
      eOut = eOe && frameBit(bitNo);
      chk(mdc == eMdc, "R3", "mdc", int'(mdc), int'(eMdc));
      chk(mdioOe == eOe, "R5", "mdioOe", int'(mdioOe), int'(eOe));
      chk(mdioOut == eOut, eOe ? "R4" : "R5", "mdioOut", int'(mdioOut), int'(eOut));
      chk(hostRdData == expRead(hostAddr), tagOf(hostAddr), "hostRdData",
          int'(hostRdData), int'(expRead(hostAddr)));
    end
  end

  // PHY model: drives the data field MSB first, one bit per MDC period
  always @(negedge clk) begin
    int b;
    b = mT / (2 * mH);
    if (mBusy && b >= 48) mdioIn <= mRet[15 - (b - 48)];
    else                  mdioIn <= 1'b1;
  end

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWe = 1'b0; hostAddr = 3'd3;
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    hostAddr = a;
    @(posedge clk);
    #3;
    chk(hostRdData == e, tag, "register read", int'(hostRdData), int'(e));
  endtask

  task automatic expectIdlePins(input string tag);
    chk(mdc == 1'b0, tag, "mdc idle", int'(mdc), 0);
    chk(mdioOe == 1'b0, tag, "mdioOe idle", int'(mdioOe), 0);
    chk(mdioOut == 1'b0, tag, "mdioOut idle", int'(mdioOut), 0);
  endtask

  task automatic runRead(input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] v, input logic [7:0] c);
    writeReg(3'd1, {3'b0, p});
    writeReg(3'd0, {3'b0, r});
    phyVal = v;
    writeReg(3'd2, c);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 6; a++) expectReg(3'(a), 8'h00, "R1");
    expectIdlePins("R1");

    // R10: address registers keep five bits
    writeReg(3'd0, 8'hE1);
    expectReg(3'd0, 8'h01, "R10");
    writeReg(3'd1, 8'hFF);
    expectReg(3'd1, 8'h1F, "R10");

    // divisor 4 read, with an ignored control write mid-transfer (R8)
    runRead(5'h1F, 5'h01, 16'hA5C3, 8'h01);
    repeat (10) @(negedge clk);
    expectReg(3'd3, 8'h01, "R2");
    expectReg(3'd2, 8'h01, "R7");
    writeReg(3'd2, 8'h04);
    expectReg(3'd2, 8'h01, "R8");
    repeat (128 * 2) @(negedge clk);
    expectReg(3'd4, 8'hC3, "R6");
    expectReg(3'd5, 8'hA5, "R6");
    expectReg(3'd2, 8'h00, "R7");
    expectReg(3'd3, 8'h00, "R2");
    expectIdlePins("R3");

    // divisor 20 read
    runRead(5'h00, 5'h12, 16'h3C5A, 8'h05);
    repeat (128 * 10 + 4) @(negedge clk);
    expectReg(3'd4, 8'h5A, "R6");
    expectReg(3'd5, 8'h3C, "R6");
    expectReg(3'd2, 8'h04, "R7");

    // divisor 40 read
    runRead(5'h0A, 5'h15, 16'h7E01, 8'h07);
    repeat (128 * 20 + 4) @(negedge clk);
    expectReg(3'd4, 8'h01, "R6");
    expectReg(3'd5, 8'h7E, "R6");

    // R9: abort mid-transfer, data kept
    runRead(5'h03, 5'h04, 16'h1234, 8'h03);
    repeat (100) @(negedge clk);
    writeReg(3'd2, 8'h80);
    expectReg(3'd3, 8'h00, "R9");
    expectIdlePins("R9");
    expectReg(3'd4, 8'h01, "R9");
    expectReg(3'd5, 8'h7E, "R9");
    expectReg(3'd2, 8'h82, "R9");
    writeReg(3'd2, 8'h81);
    repeat (3) @(negedge clk);
    expectReg(3'd3, 8'h00, "R9");
    expectReg(3'd2, 8'h80, "R9");

    // start again clears the reset bit
    runRead(5'h11, 5'h0E, 16'h8001, 8'h01);
    repeat (128 * 2 + 4) @(negedge clk);
    expectReg(3'd4, 8'h01, "R6");
    expectReg(3'd5, 8'h80, "R6");
    expectReg(3'd2, 8'h00, "R7");

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule